// File: doc/BRIEF.md
# BCD Calendar Readout Port

This block is a small peripheral port with two byte-wide registers: a command register and a data register. A host uses it to read the current date and time as packed BCD bytes. The calendar values arrive as binary numbers from an outside time source. The port itself does not keep time and does not set time.

When the command register holds the read-time code 0x15, each read of the data register returns the next field of a fixed seven-field sequence. An internal step index selects the field, and it goes back to the first field after the last one. When any other command is stored, the data register acts as a plain byte latch. Reads of either register then show an acknowledge bit forced high. Writing 0x15 to the command register restarts the sequence at its first field.

Register select: `sel_data_i` = 0 addresses the command register and `sel_data_i` = 1 addresses the data register. `rdata_o` is combinational from the current state and the current select. An index step takes effect at the clock edge that ends the read cycle.

Top module: `rtc_bcd_port`

## Requirements
- R1: After reset the command register, the data register and the step index are all 0. With no access in progress, the command register reads 0x80, and so does the data register.
- R2: Reading the command register (`sel_data_i`=0) returns the last byte written to it with bit 7 forced to 1.
- R3: While the stored command is not 0x15, reading the data register (`sel_data_i`=1) returns the last byte written to it with bit 7 forced to 1. All 8 written bits are stored.
- R4: While the stored command is 0x15, the data register presents the field chosen by the step index. Index 0 is year, 1 month, 2 day of month, 3 day of week, 4 hour, 5 minute, 6 second. Each data-register read advances the index by one at the end of that cycle.
- R5: A data-register read at index 6 (second) returns the index to 0 (year).
- R6: Each field is shown as packed BCD: the tens digit of (value mod 100) goes in bits 7:4 and the units digit in bits 3:0. This covers the year and also any field input above 99.
- R7: Writing 0x15 to the command register sets the index to 0, even part-way through a sequence.
- R8: The index changes only on a data-register read while 0x15 is stored. Command reads, data writes and idle cycles leave it unchanged. A cycle with both `wr_en_i` and `rd_en_i` high is a write only and does not advance the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe (has priority over read) |
| rd_en_i | input | 1 | Read strobe |
| sel_data_i | input | 1 | 0 = command register, 1 = data register |
| wdata_i | input | 8 | Write data |
| year_i | input | VAL_W | Binary year, taken mod 100 |
| month_i | input | VAL_W | Binary month |
| mday_i | input | VAL_W | Binary day of month |
| wday_i | input | VAL_W | Binary day of week |
| hour_i | input | VAL_W | Binary hour |
| minute_i | input | VAL_W | Binary minute |
| second_i | input | VAL_W | Binary second |
| rdata_o | output | 8 | Read data for the selected register |

## Verification
A wrong step index shows up at once as the wrong field on `rdata_o` while the data register is selected. The check does not need a read strobe, so a skipped or extra step is seen in the very next cycle. A step lost at the wrap, or a restart lost on a 0x15 write, appears on the next data-register sample as a field other than the year. A corrupted latch or a missing acknowledge bit appears on the first read of that register.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;
  localparam logic [7:0] CMD_READ_TIME = 8'h15;
  localparam int unsigned NUM_FIELDS   = 7;
  localparam int unsigned IDX_W        = $clog2(NUM_FIELDS);
  localparam logic [7:0] ACK_MASK      = 8'h80;

  typedef enum logic [IDX_W-1:0] {
    F_YEAR  = 3'd0,
    F_MONTH = 3'd1,
    F_MDAY  = 3'd2,
    F_WDAY  = 3'd3,
    F_HOUR  = 3'd4,
    F_MIN   = 3'd5,
    F_SEC   = 3'd6
  } field_e;
endpackage

// File: rtl/rtc_bin2bcd.sv
module rtc_bin2bcd #(
  parameter int unsigned VAL_W = 8
) (
  input  logic [VAL_W-1:0] val_i,
  output logic [7:0]       bcd_o
);
  localparam int unsigned MOD_W = (VAL_W > 7) ? VAL_W : 7;

  logic [MOD_W-1:0] wide;
  logic [MOD_W-1:0] two_dig;
  logic [3:0]       tens;
  logic [3:0]       units;

  always_comb begin
    wide    = MOD_W'(val_i);
    two_dig = wide % MOD_W'(100);
    tens    = 4'(two_dig / MOD_W'(10));
    units   = 4'(two_dig % MOD_W'(10));
    bcd_o   = {tens, units};
  end

  always_comb begin
    if (!$isunknown(val_i)) begin
      AST_BCD_DIGIT: assert (bcd_o[7:4] <= 4'd9 && bcd_o[3:0] <= 4'd9); // R6
    end
  end
endmodule

// File: rtl/rtc_step_ctr.sv
module rtc_step_ctr #(
  parameter int unsigned N = 7,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         step_i,
  output logic [W-1:0] idx_o
);
  localparam logic [W-1:0] LAST = W'(N - 1);

  logic [W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (clear_i) idx_q <= '0;
    else if (step_i)  idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  assign idx_o = idx_q;

  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST); // R5
  AST_IDX_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && idx_q == LAST) |=> idx_q == '0); // R5
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clear_i && idx_q != LAST) |=> idx_q == $past(idx_q) + 1'b1); // R4
endmodule

// File: rtl/rtc_bcd_port.sv
module rtc_bcd_port
  import rtc_port_pkg::*;
#(
  parameter int unsigned VAL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic             sel_data_i,
  input  logic [7:0]       wdata_i,
  input  logic [VAL_W-1:0] year_i,
  input  logic [VAL_W-1:0] month_i,
  input  logic [VAL_W-1:0] mday_i,
  input  logic [VAL_W-1:0] wday_i,
  input  logic [VAL_W-1:0] hour_i,
  input  logic [VAL_W-1:0] minute_i,
  input  logic [VAL_W-1:0] second_i,
  output logic [7:0]       rdata_o
);
  logic [7:0]       cmd_q;
  logic [7:0]       data_q;
  logic [IDX_W-1:0] idx;
  logic             time_mode;
  logic             step;
  logic             clear;
  logic [VAL_W-1:0] field_bin [NUM_FIELDS];
  logic [7:0]       field_bcd [NUM_FIELDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else if (wr_en_i) begin
      if (sel_data_i) data_q <= wdata_i;
      else            cmd_q  <= wdata_i;
    end
  end

  assign time_mode = (cmd_q == CMD_READ_TIME);
  assign clear     = wr_en_i && !sel_data_i && (wdata_i == CMD_READ_TIME);
  // write wins over read in the same cycle
  assign step      = rd_en_i && !wr_en_i && sel_data_i && time_mode;

  rtc_step_ctr #(.N(NUM_FIELDS)) u_step (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear),
    .step_i (step),
    .idx_o  (idx)
  );

  always_comb begin
    field_bin[F_YEAR]  = year_i;
    field_bin[F_MONTH] = month_i;
    field_bin[F_MDAY]  = mday_i;
    field_bin[F_WDAY]  = wday_i;
    field_bin[F_HOUR]  = hour_i;
    field_bin[F_MIN]   = minute_i;
    field_bin[F_SEC]   = second_i;
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_conv
    rtc_bin2bcd #(.VAL_W(VAL_W)) u_conv (
      .val_i(field_bin[g]),
      .bcd_o(field_bcd[g])
    );
  end

  always_comb begin
    if (!sel_data_i)    rdata_o = cmd_q | ACK_MASK;
    else if (time_mode) rdata_o = field_bcd[idx];
    else                rdata_o = data_q | ACK_MASK;
  end

  AST_CMD_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !sel_data_i) |-> rdata_o[7]); // R2
  AST_CLEAR_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear |=> idx == '0); // R7
  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step && !clear) |=> $stable(idx)); // R8
endmodule

// File: tb/rtc_bcd_port_test.sv
`timescale 1ns/1ps
module rtc_bcd_port_test;
  localparam int VAL_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en, rd_en, sel_data;
  logic [7:0] wdata;
  logic [VAL_W-1:0] year, month, mday, wday, hour, minute, second;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;
  int ref_cmd = 0;
  int ref_data = 0;
  int ref_idx = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_bcd_port #(.VAL_W(VAL_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .sel_data_i(sel_data), .wdata_i(wdata),
    .year_i(year), .month_i(month), .mday_i(mday), .wday_i(wday),
    .hour_i(hour), .minute_i(minute), .second_i(second),
    .rdata_o(rdata)
  );

  function automatic int to_bcd(int v);
    int r = v % 100;
    return ((r / 10) * 16) + (r % 10);
  endfunction

  function automatic int field_val(int i);
    case (i)
      0: return int'(year);
      1: return int'(month);
      2: return int'(mday);
      3: return int'(wday);
      4: return int'(hour);
      5: return int'(minute);
      default: return int'(second);
    endcase
  endfunction

  function automatic int model_read(bit sel);
    if (!sel) return ref_cmd | 8'h80;
    if (ref_cmd == 8'h15) return to_bcd(field_val(ref_idx));
    return ref_data | 8'h80;
  endfunction

  task automatic check(int exp, string req);
    checks++;
    if (int'(rdata) !== exp) begin
      errors++;
      $display("FAIL %s rdata=%02h expected=%02h", req, rdata, exp[7:0]);
    end
  endtask

  // one bus cycle: drive at negedge, compare before the edge, advance model
  task automatic cyc(bit w, bit r, bit s, logic [7:0] d, string req);
    @(negedge clk);
    wr_en = w; rd_en = r; sel_data = s; wdata = d;
    #1;
    check(model_read(s), req);
    if (w) begin
      if (!s) begin
        ref_cmd = int'(d);
        if (d == 8'h15) ref_idx = 0;
      end else ref_data = int'(d);
    end else if (r && s && ref_cmd == 8'h15) begin
      ref_idx = (ref_idx == 6) ? 0 : ref_idx + 1;
    end
  endtask

  task automatic set_time(int y, int mo, int md, int wd, int h, int mi, int se);
    year = VAL_W'(y); month = VAL_W'(mo); mday = VAL_W'(md); wday = VAL_W'(wd);
    hour = VAL_W'(h); minute = VAL_W'(mi); second = VAL_W'(se);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wr_en = 0; rd_en = 0; sel_data = 0; wdata = 0;
    set_time(124, 12, 31, 6, 23, 59, 58);
    #12;
    sel_data = 0; #1; check(8'h80, "R1");
    sel_data = 1; #1; check(8'h80, "R1");
    rst_ni = 1'b1;
    cyc(0, 0, 1, 0, "R1");

    // R2 command readback
    cyc(1, 0, 0, 8'h3C, "R2");
    cyc(0, 1, 0, 0, "R2");
    cyc(1, 0, 0, 8'h81, "R2");
    cyc(0, 1, 0, 0, "R2");

    // R3 plain latch
    cyc(1, 0, 1, 8'h5A, "R3");
    cyc(0, 1, 1, 0, "R3");
    cyc(0, 1, 1, 0, "R3");
    cyc(1, 0, 1, 8'hFF, "R3");
    cyc(0, 1, 1, 0, "R3");
    cyc(1, 0, 1, 8'h07, "R3");
    cyc(0, 1, 1, 0, "R3");

    // R4 full sequence, R5 wrap
    cyc(1, 0, 0, 8'h15, "R7");
    for (int i = 0; i < 7; i++) cyc(0, 1, 1, 0, "R4");
    cyc(0, 1, 1, 0, "R5");
    cyc(0, 1, 1, 0, "R5");

    // R6 BCD of out-of-range and small values
    set_time(99, 0, 7, 0, 200, 9, 100);
    cyc(1, 0, 0, 8'h15, "R7");
    for (int i = 0; i < 14; i++) cyc(0, 1, 1, 0, "R6");

    // R7 restart mid-sequence
    set_time(255, 1, 15, 3, 12, 30, 45);
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 0, "R4");
    cyc(1, 0, 0, 8'h15, "R7");
    cyc(0, 0, 1, 0, "R7");
    cyc(0, 1, 1, 0, "R7");

    // R8 index held by other accesses
    cyc(0, 1, 0, 0, "R8");
    cyc(0, 0, 1, 0, "R8");
    cyc(1, 0, 1, 8'h22, "R8");
    cyc(0, 0, 1, 0, "R8");
    cyc(1, 1, 1, 8'h33, "R8");
    cyc(0, 0, 1, 0, "R8");
    cyc(0, 1, 1, 0, "R8");
    cyc(0, 0, 1, 0, "R8");
    // index parked at 2 while another command is stored, then restart
    cyc(1, 0, 0, 8'h00, "R2");
    cyc(0, 1, 1, 0, "R3");
    cyc(0, 1, 1, 0, "R3");
    cyc(1, 0, 0, 8'h15, "R7");
    cyc(0, 0, 1, 0, "R7");

    // long random-ish traffic against the model
    for (int i = 0; i < 300; i++) begin
      bit w = (i % 11) == 3;
      bit r = (i % 3) != 0;
      bit s = (i % 5) != 1;
      logic [7:0] d = (i % 22 == 3) ? 8'h15 : 8'(i * 37);
      if (i % 40 == 0) set_time(i % 256, i % 13, i % 32, i % 7, i % 24, i % 60, (i * 7) % 128);
      cyc(w, r, s, d, "R8");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule